// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block walks a clock generator from its post-reset or bypassed condition into locked PLL operation without software involvement in the timing. A host presents a multiplier, a divisor and a one-cycle start strobe. The block first range-checks both values. If they are valid, it derives the encoded control fields, splits them across two control words, and drives the saturation-enable, PLL-enable, enable-source, bypass, power-down and PLL-reset controls in a fixed order. Every wait in the order is counted in reference-clock cycles.

The path depends on the bypass control at the moment of start. If bypass is already set, the block does the full power-cycle path. Otherwise it takes a short path, whose first wait is scaled by the multiplication ratio. Both paths end in a common reset, lock and switch-over phase. The analog PLL is represented only by a lock-indication input. The run finishes with a one-cycle done pulse or a one-cycle error pulse, and an error code is held on a separate output.

Top module: `pllup_sequencer`

## Requirements
- R1: A start with divisor 0 gives error code 1, divisor above 64 code 2, multiplier 0 code 3, and multiplier above 4096 code 4. The divisor is tested before the multiplier. The error pulse follows the start edge by zero cycles (visible right after that edge), and no control output or control word changes.
- R2: When bypass is set at start, the actions are: saturation-enable set (edge 1), PLL enable cleared (2), enable-source cleared (3), a 4-cycle wait, bypass set (8), power-down asserted (9), a wait of 5×CYC_PER_US cycles, and power-down released (10+5×CYC_PER_US).
- R3: When bypass is clear at start, the actions are: PLL enable cleared (edge 1), enable-source cleared (2), then a wait of 4×multiplier/divisor cycles (integer, at least 1).
- R4: The encoded multiplier E = 2×multiplier−1. E[5:0] goes to word_b bits [5:0], and E[12:6] goes to word_a bits [12:6].
- R5: The bandwidth field B = ((E+1)>>1)−1. B[7:0] goes to word_a bits [20:13], and B[11:8] goes to word_b bits [9:6].
- R6: word_a bits [5:0] hold divisor−1, and word_b bits [13:10] hold 1 (divide by two). Both words are written on one edge, P, which comes one edge after the branch ends.
- R7: PLL reset rises at P+1 and falls at P+2+7×CYC_PER_US. Bypass clears at P+3+7×CYC_PER_US+LOCK_PER_DIV×divisor, and the PLL enable sets on the following edge.
- R8: done_o is high for exactly one cycle, one cycle after the PLL enable sets.
- R9: A start strobe during a running sequence has no effect on outputs, words or timing.
- R10: If lock_i is low when the lock wait ends, the block gives error code 5 on that edge, clears nothing further and returns to idle.
- R11: After reset: saturation-enable 0, PLL enable 0, enable-source 1, bypass BYP_RST (1), power-down 0, PLL reset 0, both words 0, done 0, error 0, code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| mult_i | input | 13 | Requested multiplier |
| div_i | input | 7 | Requested input divisor |
| lock_i | input | 1 | Lock indication from the PLL model |
| ensat_o | output | 1 | Saturation-enable control |
| pll_en_o | output | 1 | PLL enable (controller mux select) |
| en_src_o | output | 1 | Enable-source select |
| bypass_o | output | 1 | Bypass control of the PLL mux |
| pwrdn_o | output | 1 | PLL power-down |
| pll_rst_o | output | 1 | PLL reset |
| word_a_o | output | 21 | Control word A: bandwidth low, multiplier high, divisor field |
| word_b_o | output | 14 | Control word B: output divide, bandwidth high, multiplier low |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 3 | Last error code (0 none) |

## Verification
Each run counts edges from the start edge, E0. The error pulse for bad parameters is due at E0. Power-down release and word programming are due at fixed offsets given by the branch formulas. Reset, bypass release, enable and done follow at P plus the reset and lock windows. The driver computes every offset from the requirements, timestamped with absolute cycle numbers, and queues them. The monitor samples on the falling clock edge and checks each output change against the head of the queue for cycle, signal and value. After each run a quiet window confirms that nothing unexpected changed, which covers the ignored start and the rejected parameters.

// File: rtl/pllup_pkg.sv
package pllup_pkg;
    localparam int MULT_W   = 13;
    localparam int DIV_W    = 7;
    localparam int ENC_W    = 13;
    localparam int BW_W     = 12;
    localparam int DIVF_W   = 6;
    localparam int OD_W     = 4;
    localparam int MULT_MAX = 4096;
    localparam int DIV_MAX  = 64;
    localparam int WA_W     = 8 + (ENC_W - 6) + DIVF_W;
    localparam int WB_W     = OD_W + (BW_W - 8) + 6;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_DIV_ZERO = 3'd1,
        ERR_DIV_BIG  = 3'd2,
        ERR_MUL_ZERO = 3'd3,
        ERR_MUL_BIG  = 3'd4,
        ERR_NO_LOCK  = 3'd5
    } err_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_SATEN, ST_PLLOFF, ST_SRCOFF, ST_W4, ST_BYPON, ST_PDON,
        ST_WPD, ST_PDOFF, ST_WSCL, ST_PROG, ST_RSTON, ST_WRST, ST_RSTOFF,
        ST_WLOCK, ST_BYPOFF, ST_PLLON, ST_DONE
    } st_e;

    typedef struct packed {
        logic [7:0]        bw_lo;
        logic [ENC_W-7:0]  enc_hi;
        logic [DIVF_W-1:0] div_f;
    } word_a_t;

    typedef struct packed {
        logic [OD_W-1:0]  od;
        logic [BW_W-9:0]  bw_hi;
        logic [5:0]       enc_lo;
    } word_b_t;

    function automatic err_e check_params(logic [MULT_W-1:0] m, logic [DIV_W-1:0] d);
        if (d == '0)                        return ERR_DIV_ZERO;
        if (int'(d) > DIV_MAX)              return ERR_DIV_BIG;
        if (m == '0)                        return ERR_MUL_ZERO;
        if (int'(m) > MULT_MAX)             return ERR_MUL_BIG;
        return ERR_NONE;
    endfunction

    function automatic logic [ENC_W-1:0] encode_mult(logic [MULT_W-1:0] m);
        logic [MULT_W:0] t;
        t = {m, 1'b0} - 1'b1;
        return t[ENC_W-1:0];
    endfunction

    function automatic logic [BW_W-1:0] bw_adjust(logic [ENC_W-1:0] e);
        logic [ENC_W:0] t;
        t = ({1'b0, e} + 1'b1) >> 1;
        t = t - 1'b1;
        return t[BW_W-1:0];
    endfunction
endpackage

// File: rtl/pllup_fields.sv
module pllup_fields
    import pllup_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic [MULT_W-1:0] mult_i,
    input  logic [DIV_W-1:0]  div_i,
    output word_a_t           word_a_o,
    output word_b_t           word_b_o,
    output logic [CNT_W-1:0]  scaled_wait_o
);
    localparam int Q_W = MULT_W + 2;

    logic [ENC_W-1:0] enc;
    logic [BW_W-1:0]  bw;
    logic [Q_W-1:0]   quot;

    always_comb begin
        enc = encode_mult(mult_i);
        bw  = bw_adjust(enc);

        word_a_o.bw_lo  = bw[7:0];
        word_a_o.enc_hi = enc[ENC_W-1:6];
        word_a_o.div_f  = DIVF_W'(div_i - 1'b1);

        word_b_o.od     = OD_W'(1);
        word_b_o.bw_hi  = bw[BW_W-1:8];
        word_b_o.enc_lo = enc[5:0];

        quot = (div_i == '0) ? '0 : ({mult_i, 2'b00} / Q_W'(div_i));
        scaled_wait_o = (quot == '0) ? CNT_W'(1) : CNT_W'(quot);
    end
endmodule

// File: rtl/pllup_waitctr.sv
module pllup_waitctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (load_i)         cnt_q <= val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == CNT_W'(1));

    // R7
    expire_next_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !load_i) |=> !expire_o);
endmodule

// File: rtl/pllup_sequencer.sv
module pllup_sequencer
    import pllup_pkg::*;
#(
    parameter int   CYC_PER_US   = 100,
    parameter int   LOCK_PER_DIV = 2000,
    parameter int   CNT_W        = 20,
    parameter logic BYP_RST      = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              lock_i,
    output logic              ensat_o,
    output logic              pll_en_o,
    output logic              en_src_o,
    output logic              bypass_o,
    output logic              pwrdn_o,
    output logic              pll_rst_o,
    output logic [WA_W-1:0]   word_a_o,
    output logic [WB_W-1:0]   word_b_o,
    output logic              done_o,
    output logic              err_o,
    output logic [2:0]        err_code_o
);
    localparam logic [CNT_W-1:0] T_MUX = CNT_W'(4);
    localparam logic [CNT_W-1:0] T_PD  = CNT_W'(5 * CYC_PER_US);
    localparam logic [CNT_W-1:0] T_RST = CNT_W'(7 * CYC_PER_US);

    st_e               state_q;
    logic [MULT_W-1:0] m_q;
    logic [DIV_W-1:0]  d_q;
    logic              byp_q;
    err_e              chk;
    word_a_t           wa;
    word_b_t           wb;
    logic [CNT_W-1:0]  scaled;
    logic [CNT_W-1:0]  lock_cyc;
    logic              ld;
    logic [CNT_W-1:0]  ld_val;
    logic              expire;

    pllup_fields #(.CNT_W(CNT_W)) fields_i (
        .mult_i       (m_q),
        .div_i        (d_q),
        .word_a_o     (wa),
        .word_b_o     (wb),
        .scaled_wait_o(scaled)
    );

    pllup_waitctr #(.CNT_W(CNT_W)) wait_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (ld),
        .val_i   (ld_val),
        .expire_o(expire)
    );

    assign chk      = check_params(mult_i, div_i);
    assign lock_cyc = CNT_W'(LOCK_PER_DIV * int'(d_q));

    always_comb begin
        ld     = 1'b0;
        ld_val = '0;
        case (state_q)
            ST_SRCOFF: begin ld = 1'b1; ld_val = byp_q ? T_MUX : scaled; end
            ST_PDON:   begin ld = 1'b1; ld_val = T_PD;     end
            ST_RSTON:  begin ld = 1'b1; ld_val = T_RST;    end
            ST_RSTOFF: begin ld = 1'b1; ld_val = lock_cyc; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            m_q        <= '0;
            d_q        <= '0;
            byp_q      <= 1'b0;
            ensat_o    <= 1'b0;
            pll_en_o   <= 1'b0;
            en_src_o   <= 1'b1;
            bypass_o   <= BYP_RST;
            pwrdn_o    <= 1'b0;
            pll_rst_o  <= 1'b0;
            word_a_o   <= '0;
            word_b_o   <= '0;
            done_o     <= 1'b0;
            err_o      <= 1'b0;
            err_code_o <= ERR_NONE;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    if (chk != ERR_NONE) begin
                        err_o      <= 1'b1;
                        err_code_o <= chk;
                    end else begin
                        m_q        <= mult_i;
                        d_q        <= div_i;
                        byp_q      <= bypass_o;
                        err_code_o <= ERR_NONE;
                        state_q    <= bypass_o ? ST_SATEN : ST_PLLOFF;
                    end
                end
                ST_SATEN:  begin ensat_o  <= 1'b1; state_q <= ST_PLLOFF; end
                ST_PLLOFF: begin pll_en_o <= 1'b0; state_q <= ST_SRCOFF; end
                ST_SRCOFF: begin
                    en_src_o <= 1'b0;
                    state_q  <= byp_q ? ST_W4 : ST_WSCL;
                end
                ST_W4:     if (expire) state_q <= ST_BYPON;
                ST_BYPON:  begin bypass_o <= 1'b1; state_q <= ST_PDON; end
                ST_PDON:   begin pwrdn_o  <= 1'b1; state_q <= ST_WPD;  end
                ST_WPD:    if (expire) state_q <= ST_PDOFF;
                ST_PDOFF:  begin pwrdn_o  <= 1'b0; state_q <= ST_PROG; end
                ST_WSCL:   if (expire) state_q <= ST_PROG;
                ST_PROG: begin
                    word_a_o <= wa;
                    word_b_o <= wb;
                    state_q  <= ST_RSTON;
                end
                ST_RSTON:  begin pll_rst_o <= 1'b1; state_q <= ST_WRST;  end
                ST_WRST:   if (expire) state_q <= ST_RSTOFF;
                ST_RSTOFF: begin pll_rst_o <= 1'b0; state_q <= ST_WLOCK; end
                ST_WLOCK: if (expire) begin
                    if (lock_i) state_q <= ST_BYPOFF;
                    else begin
                        err_o      <= 1'b1;
                        err_code_o <= ERR_NO_LOCK;
                        state_q    <= ST_IDLE;
                    end
                end
                ST_BYPOFF: begin bypass_o <= 1'b0; state_q <= ST_PLLON; end
                ST_PLLON:  begin pll_en_o <= 1'b1; state_q <= ST_DONE;  end
                ST_DONE:   begin done_o   <= 1'b1; state_q <= ST_IDLE;  end
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // R1
    reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (err_o && err_code_o != ERR_NO_LOCK) |-> ($stable(word_a_o) && $stable(pll_en_o) && $stable(bypass_o)));

    // R2
    pwrdn_bypassed_chk: assert property (@(posedge clk) disable iff (rst)
        pwrdn_o |-> (bypass_o && !pll_en_o));

    // R7
    rst_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        pll_rst_o |-> !pll_en_o);

    // R7
    en_after_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en_o) |-> !bypass_o);

    // R8
    done_after_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en_o) |=> done_o);

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && start_i) |=> ($stable(m_q) && $stable(d_q)));
endmodule

// File: tb/pllup_sequencer_tb.sv
module pllup_sequencer_tb_top;
    localparam int CPU = 2;
    localparam int LPD = 5;
    localparam int NPD = 5 * CPU;
    localparam int NR  = 7 * CPU;

    localparam int K_ENSAT = 0, K_EN = 1, K_SRC = 2, K_BYP = 3, K_PD = 4,
                   K_RST = 5, K_WA = 6, K_WB = 7, K_DONE = 8, K_ERR = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [12:0] mult_i = '0;
    logic [6:0]  div_i = '0;
    logic        lock_i = 1'b1;
    logic        ensat_o, pll_en_o, en_src_o, bypass_o, pwrdn_o, pll_rst_o;
    logic [20:0] word_a_o;
    logic [13:0] word_b_o;
    logic        done_o, err_o;
    logic [2:0]  err_code_o;

    pllup_sequencer #(.CYC_PER_US(CPU), .LOCK_PER_DIV(LPD)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mult_i(mult_i), .div_i(div_i),
        .lock_i(lock_i), .ensat_o(ensat_o), .pll_en_o(pll_en_o), .en_src_o(en_src_o),
        .bypass_o(bypass_o), .pwrdn_o(pwrdn_o), .pll_rst_o(pll_rst_o),
        .word_a_o(word_a_o), .word_b_o(word_b_o), .done_o(done_o), .err_o(err_o),
        .err_code_o(err_code_o)
    );

    always #10 clk = ~clk;

    typedef struct {
        int    cyc;
        int    kind;
        int    val;
        string req;
    } ev_t;

    ev_t exp_q[$];
    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    int  t0 = 0;
    bit  mon_en = 1'b0;
    int  prev[10];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic int exp_wa(int m, int d);
        int e, b;
        e = 2 * m - 1;
        b = ((e + 1) >> 1) - 1;
        return ((b & 255) << 13) | ((e >> 6) << 6) | (d - 1);
    endfunction

    function automatic int exp_wb(int m);
        int e, b;
        e = 2 * m - 1;
        b = ((e + 1) >> 1) - 1;
        return (1 << 10) | ((b >> 8) << 6) | (e & 63);
    endfunction

    task automatic push(input int off, input int kind, input int val, input string req);
        ev_t e;
        e.cyc = t0 + off; e.kind = kind; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: every output change is compared with the head of the queue.
    always @(negedge clk) begin
        int cur[10];
        cur[K_ENSAT] = int'(ensat_o);   cur[K_EN]  = int'(pll_en_o);
        cur[K_SRC]   = int'(en_src_o);  cur[K_BYP] = int'(bypass_o);
        cur[K_PD]    = int'(pwrdn_o);   cur[K_RST] = int'(pll_rst_o);
        cur[K_WA]    = int'(word_a_o);  cur[K_WB]  = int'(word_b_o);
        cur[K_DONE]  = int'(done_o);    cur[K_ERR] = int'(err_o);
        if (mon_en) begin
            for (int k = 0; k < 10; k++) begin
                if (cur[k] != prev[k] && (k < K_DONE || cur[k] == 1)) begin
                    int v;
                    v = (k == K_ERR) ? int'(err_code_o) : cur[k];
                    if (exp_q.size() == 0) begin
                        check(1'b0, "unexpected-change", k, -1);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        check(e.kind == k, e.req, k, e.kind);
                        check(e.cyc == cyc, e.req, cyc, e.cyc);
                        check(e.val == v, e.req, v, e.val);
                    end
                end
            end
        end
        prev = cur;
    end

    task automatic kick(input int m, input int d);
        @(negedge clk);
        mult_i = 13'(m); div_i = 7'(d); start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        t0 = cyc;
    endtask

    task automatic drain(input string req);
        int guard = 0;
        while (exp_q.size() != 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(ensat_o == 0,   "R11 ensat", ensat_o, 0);
        check(pll_en_o == 0,  "R11 pll_en", pll_en_o, 0);
        check(en_src_o == 1,  "R11 en_src", en_src_o, 1);
        check(bypass_o == 1,  "R11 bypass", bypass_o, 1);
        check(pwrdn_o == 0 && pll_rst_o == 0, "R11 pwrdn/rst", pwrdn_o, 0);
        check(word_a_o == 0 && word_b_o == 0, "R11 words", int'(word_a_o), 0);
        check(done_o == 0 && err_o == 0 && err_code_o == 0, "R11 flags", int'(err_code_o), 0);
        mon_en = 1'b1;

        // R2 R4 R5 R6 R7 R8: bypass branch, m=20 d=2
        kick(20, 2);
        push(1, K_ENSAT, 1, "R2 ensat");
        push(3, K_SRC, 0, "R2 en_src");
        push(9, K_PD, 1, "R2 pwrdn on");
        push(10 + NPD, K_PD, 0, "R2 pwrdn off");
        push(11 + NPD, K_WA, exp_wa(20, 2), "R4 R5 R6 word_a");
        push(11 + NPD, K_WB, exp_wb(20), "R4 R5 R6 word_b");
        push(12 + NPD, K_RST, 1, "R7 rst on");
        push(13 + NPD + NR, K_RST, 0, "R7 rst off");
        push(14 + NPD + NR + LPD * 2, K_BYP, 0, "R7 bypass off");
        push(15 + NPD + NR + LPD * 2, K_EN, 1, "R7 enable");
        push(16 + NPD + NR + LPD * 2, K_DONE, 1, "R8 done");
        drain("R2 sequence complete");

        // R3 R9: short branch, m=100 d=5, scaled wait 80; stray start ignored
        kick(100, 5);
        push(1, K_EN, 0, "R3 pll_en off");
        push(83, K_WA, exp_wa(100, 5), "R3 R4 word_a");
        push(83, K_WB, exp_wb(100), "R3 R5 word_b");
        push(84, K_RST, 1, "R7 rst on");
        push(85 + NR, K_RST, 0, "R7 rst off");
        push(87 + NR + LPD * 5, K_EN, 1, "R7 enable");
        push(88 + NR + LPD * 5, K_DONE, 1, "R8 done");
        repeat (40) @(negedge clk);
        mult_i = 13'd7; div_i = 7'd1; start_i = 1'b1;   // R9 stray start
        @(negedge clk);
        start_i = 1'b0;
        drain("R9 stray start ignored");

        // R4 R5 R6 maximum values, m=4096 d=64, scaled wait 256
        kick(4096, 64);
        push(1, K_EN, 0, "R3 pll_en off");
        push(259, K_WA, 2097151, "R4 R5 R6 word_a max");
        push(259, K_WB, 2047, "R4 R5 R6 word_b max");
        push(260, K_RST, 1, "R7 rst on");
        push(261 + NR, K_RST, 0, "R7 rst off");
        push(263 + NR + LPD * 64, K_EN, 1, "R7 enable");
        push(264 + NR + LPD * 64, K_DONE, 1, "R8 done");
        drain("R6 max complete");

        // R1 parameter rejection
        kick(10, 0);   push(0, K_ERR, 1, "R1 div zero");  drain("R1 quiet after div zero");
        kick(10, 65);  push(0, K_ERR, 2, "R1 div big");   drain("R1 quiet after div big");
        kick(0, 4);    push(0, K_ERR, 3, "R1 mult zero"); drain("R1 quiet after mult zero");
        kick(4097, 4); push(0, K_ERR, 4, "R1 mult big");  drain("R1 quiet after mult big");
        kick(0, 0);    push(0, K_ERR, 1, "R1 divisor first"); drain("R1 quiet after both bad");
        check(pll_en_o == 1 && bypass_o == 0, "R1 controls untouched", pll_en_o, 1);

        // R10 no lock: m=20 d=2, scaled wait 40
        lock_i = 1'b0;
        kick(20, 2);
        push(1, K_EN, 0, "R3 pll_en off");
        push(43, K_WA, exp_wa(20, 2), "R4 word_a");
        push(43, K_WB, exp_wb(20), "R5 word_b");
        push(44, K_RST, 1, "R7 rst on");
        push(45 + NR, K_RST, 0, "R7 rst off");
        push(45 + NR + LPD * 2, K_ERR, 5, "R10 no lock");
        drain("R10 stops after lock error");
        check(pll_en_o == 0, "R10 enable stays low", pll_en_o, 0);

        // R3 minimum scaled wait: m=1 d=64 gives 0, clamped to 1
        lock_i = 1'b1;
        kick(1, 64);
        push(4, K_WA, exp_wa(1, 64), "R3 min wait word_a");
        push(4, K_WB, exp_wb(1), "R3 min wait word_b");
        push(5, K_RST, 1, "R7 rst on");
        push(6 + NR, K_RST, 0, "R7 rst off");
        push(8 + NR + LPD * 64, K_EN, 1, "R7 enable");
        push(9 + NR + LPD * 64, K_DONE, 1, "R8 done");
        drain("R3 min wait complete");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule